// File: doc/BRIEF.md
# Receive Resource Ring Manager

This block keeps track of a circular table of receive buffer descriptors that lives in host memory. Four pointer registers bound and walk the table: a start pointer, an end pointer, a read pointer (the next entry to consume) and a write pointer (the first entry the host has not yet handed over). Each table entry describes one buffer with a 32-bit base address and a 32-bit word count, stored as four 16-bit fields. The block fetches one entry either on a software command or automatically when the receive side reports that the current buffer has been closed out. It then presents the loaded buffer on its outputs.

After each fetch the read pointer steps to the next entry and wraps to the start pointer at the end of the table. When the read pointer has caught up with the write pointer, the block raises a sticky resources-exhausted flag. This tells the host that the buffer just loaded is the last one. If a buffer is closed out while no further entry exists, a stop latch engages so that the receive side drops later packets. The next successful fetch releases the latch.

The fetch engine is a four-state machine. IDLE waits for work. FETCH issues four memory reads, one per field, holding each request until it is acknowledged. ADVANCE loads the buffer outputs and steps the read pointer. FINISH evaluates the exhausted condition, retires the command bit and releases the stop latch. The transitions are IDLE to FETCH (command pending, or buffer closed with entries left), FETCH to FETCH (field acknowledged, more to read), FETCH to ADVANCE (last field acknowledged), ADVANCE to FINISH (always) and FINISH to IDLE (always). A buffer close seen in IDLE with no entries left and no command pending keeps the machine in IDLE and sets the stop latch.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset all four pointers read as zero, and `rx_stop`, `irq_exhausted`, `cmd_pending` and `busy` are low.
- R2: Pointer writes select a register with `reg_sel` (0 start, 1 end, 2 read, 3 write). The stored value has bits [1:0] cleared when `wide_mode` is 1 and bit 0 cleared when it is 0.
- R3: A fetch reads four fields in the order buffer-low, buffer-high, count-low, count-high. Field k is at `rd + 2k` in narrow mode and at `rd + 4k` in wide mode. Afterwards `buf_base` = {buffer-high, buffer-low} and `buf_wcnt` = {count-high, count-low}.
- R4: After a fetch the read pointer moves forward by 8 in narrow mode and by 16 in wide mode.
- R5: If the advanced read pointer equals the end pointer, the read pointer is loaded with the start pointer instead.
- R6: If the read pointer equals the write pointer after a fetch, `irq_exhausted` is set. It stays set until an `exh_ack` pulse.
- R7: A `cmd_fetch` pulse sets `cmd_pending`. The bit stays high through the fetch and clears by itself when the fetch completes.
- R8: A `buf_full` pulse in IDLE with read pointer equal to write pointer and no command pending sets `rx_stop`. No memory read is issued and the read pointer does not move.
- R9: A `buf_full` pulse in IDLE with read pointer different from write pointer starts a fetch with no command.
- R10: Completion of any fetch clears `rx_stop`.
- R11: A `buf_full` pulse while the engine is busy is ignored and causes no further fetch.
- R12: `mem_req` and `mem_addr` stay unchanged from the request until the cycle `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1: 32-bit data mode, 0: 16-bit data mode |
| reg_we | input | 1 | Pointer register write strobe |
| reg_sel | input | 2 | Pointer select (0 start, 1 end, 2 read, 3 write) |
| reg_wdata | input | 16 | Pointer write data |
| reg_rdata | output | 16 | Stored value of the selected pointer |
| cmd_fetch | input | 1 | Fetch-resource command pulse |
| cmd_pending | output | 1 | Fetch command bit, self-clearing |
| buf_full | input | 1 | Current buffer closed out by a packet |
| exh_ack | input | 1 | Clears the exhausted flag |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_ack | input | 1 | Read data valid, request accepted |
| mem_rdata | input | 16 | Read data |
| buf_base | output | 32 | Base address of the loaded buffer |
| buf_wcnt | output | 32 | Word count of the loaded buffer |
| busy | output | 1 | Fetch engine not in IDLE |
| rx_stop | output | 1 | Last buffer full, reception stopped |
| irq_exhausted | output | 1 | Resources-exhausted flag |

## Verification
The bench walks a four-entry narrow table to its end, so the final fetch both wraps the read pointer and lands on the write pointer. A design that compared before advancing, or that failed to wrap, would show a wrong read pointer or a missing exhausted flag. It then closes a buffer with no entries left and expects the stop latch with no memory traffic; a design that fetched anyway would produce an unexpected request at the memory model. The same walk runs in wide mode with misaligned pointer writes, which catches a wrong alignment mask or field stride. A buffer close pulsed in the middle of a command fetch must not start a second fetch, and the command bit must drop only at completion.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

    typedef enum logic [1:0] {
        PTR_START = 2'd0,
        PTR_END   = 2'd1,
        PTR_READ  = 2'd2,
        PTR_WRITE = 2'd3
    } ptr_sel_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FETCH,
        S_ADVANCE,
        S_FINISH
    } fetch_state_e;

    localparam int NUM_FIELDS = 4;
    localparam int NUM_PTRS   = 4;

endpackage

// File: rtl/rrm_ring_regs.sv
module rrm_ring_regs
    import rrm_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_mode,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          adv,
    output logic [AW-1:0] rd_data,
    output logic [AW-1:0] start_ptr,
    output logic [AW-1:0] end_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [AW-1:0] wr_ptr,
    output logic          rd_eq_wr
);

    localparam int NARROW_STEP = NUM_FIELDS * 2;
    localparam int WIDE_STEP   = NUM_FIELDS * 4;

    logic [NUM_PTRS-1:0][AW-1:0] ptr_q;
    logic [AW-1:0] align_mask;
    logic [AW-1:0] step;
    logic [AW-1:0] rd_stepped;
    logic [AW-1:0] rd_next;

    assign align_mask = wide_mode ? {{(AW-2){1'b1}}, 2'b00} : {{(AW-1){1'b1}}, 1'b0};
    assign step       = wide_mode ? AW'(WIDE_STEP) : AW'(NARROW_STEP);
    assign rd_stepped = ptr_q[PTR_READ] + step;
    assign rd_next    = (rd_stepped == ptr_q[PTR_END]) ? ptr_q[PTR_START] : rd_stepped;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            for (int i = 0; i < NUM_PTRS; i++) begin
                if ((i == int'(PTR_READ)) && adv) begin
                    ptr_q[i] <= rd_next;
                end else if (wr_en && (wr_sel == 2'(i))) begin
                    ptr_q[i] <= wr_data & align_mask;
                end
            end
        end
    end

    assign start_ptr = ptr_q[PTR_START];
    assign end_ptr   = ptr_q[PTR_END];
    assign rd_ptr    = ptr_q[PTR_READ];
    assign wr_ptr    = ptr_q[PTR_WRITE];
    assign rd_data   = ptr_q[wr_sel];
    assign rd_eq_wr  = (ptr_q[PTR_READ] == ptr_q[PTR_WRITE]);

    // R2
    wide_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == PTR_START && wide_mode) |=> start_ptr[1:0] == 2'b00);

    // R2
    narrow_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == PTR_WRITE && !wide_mode) |=> wr_ptr[0] == 1'b0);

    // R5
    ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && (rd_ptr + step == end_ptr)) |=> rd_ptr == $past(start_ptr));

    // R4
    ring_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && (rd_ptr + step != end_ptr)) |=> rd_ptr == $past(rd_ptr) + $past(step));

endmodule

// File: rtl/rrm_fetch_ctrl.sv
module rrm_fetch_ctrl
    import rrm_pkg::*;
#(
    parameter int AW = 16,
    parameter int FW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wide_mode,
    input  logic            cmd_fetch,
    input  logic            buf_full,
    input  logic            exh_ack,
    input  logic [AW-1:0]   rd_ptr,
    input  logic            rd_eq_wr,
    input  logic            mem_ack,
    input  logic [FW-1:0]   mem_rdata,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    output logic            adv,
    output logic [2*FW-1:0] buf_base,
    output logic [2*FW-1:0] buf_wcnt,
    output logic            cmd_pending,
    output logic            busy,
    output logic            rx_stop,
    output logic            irq_exhausted
);

    localparam int IW = $clog2(NUM_FIELDS);

    fetch_state_e state_q, state_d;
    logic [IW-1:0] idx_q;
    logic [NUM_FIELDS-1:0][FW-1:0] fld_q;
    logic [AW-1:0] field_off;
    logic start_fetch;
    logic last_field;

    assign start_fetch = cmd_pending || (buf_full && !rd_eq_wr);
    assign last_field  = (idx_q == IW'(NUM_FIELDS - 1));
    assign field_off   = wide_mode ? (AW'(idx_q) << 2) : (AW'(idx_q) << 1);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start_fetch) state_d = S_FETCH;
            S_FETCH:   if (mem_ack && last_field) state_d = S_ADVANCE;
            S_ADVANCE: state_d = S_FINISH;
            S_FINISH:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs of the machine
    always_comb begin
        mem_req  = 1'b0;
        mem_addr = '0;
        adv      = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            S_IDLE:    busy = 1'b0;
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = rd_ptr + field_off;
            end
            S_ADVANCE: adv = 1'b1;
            S_FINISH:  ;
            default:   busy = 1'b0;
        endcase
    end

    // field index and capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            fld_q <= '0;
        end else if (state_q != S_FETCH) begin
            idx_q <= '0;
        end else if (mem_ack) begin
            fld_q[idx_q] <= mem_rdata;
            idx_q        <= idx_q + 1'b1;
        end
    end

    // loaded buffer descriptor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_base <= '0;
            buf_wcnt <= '0;
        end else if (state_q == S_ADVANCE) begin
            buf_base <= {fld_q[1], fld_q[0]};
            buf_wcnt <= {fld_q[3], fld_q[2]};
        end
    end

    // command bit, stop latch, exhausted flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_pending   <= 1'b0;
            rx_stop       <= 1'b0;
            irq_exhausted <= 1'b0;
        end else begin
            if (cmd_fetch)                  cmd_pending <= 1'b1;
            else if (state_q == S_FINISH)   cmd_pending <= 1'b0;

            if (state_q == S_FINISH)
                rx_stop <= 1'b0;
            else if (state_q == S_IDLE && buf_full && rd_eq_wr && !cmd_pending)
                rx_stop <= 1'b1;

            if (state_q == S_FINISH && rd_eq_wr) irq_exhausted <= 1'b1;
            else if (exh_ack)                    irq_exhausted <= 1'b0;
        end
    end

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R6
    exhaust_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FINISH && rd_eq_wr) |=> irq_exhausted);

    // R7
    cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FINISH && !cmd_fetch) |=> !cmd_pending);

    // R8
    stop_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && buf_full && rd_eq_wr && !cmd_pending) |=> (rx_stop && !mem_req));

    // R9
    auto_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && buf_full && !rd_eq_wr) |=> mem_req);

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FINISH) |=> !rx_stop);

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH && buf_full && !cmd_pending && !rx_stop) |=> !rx_stop);

endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
    import rrm_pkg::*;
#(
    parameter int AW = 16,
    parameter int FW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wide_mode,
    input  logic            reg_we,
    input  logic [1:0]      reg_sel,
    input  logic [AW-1:0]   reg_wdata,
    output logic [AW-1:0]   reg_rdata,
    input  logic            cmd_fetch,
    output logic            cmd_pending,
    input  logic            buf_full,
    input  logic            exh_ack,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_ack,
    input  logic [FW-1:0]   mem_rdata,
    output logic [2*FW-1:0] buf_base,
    output logic [2*FW-1:0] buf_wcnt,
    output logic            busy,
    output logic            rx_stop,
    output logic            irq_exhausted
);

    logic [AW-1:0] start_ptr, end_ptr, rd_ptr, wr_ptr;
    logic          rd_eq_wr;
    logic          adv;

    rrm_ring_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide_mode (wide_mode),
        .wr_en     (reg_we),
        .wr_sel    (reg_sel),
        .wr_data   (reg_wdata),
        .adv       (adv),
        .rd_data   (reg_rdata),
        .start_ptr (start_ptr),
        .end_ptr   (end_ptr),
        .rd_ptr    (rd_ptr),
        .wr_ptr    (wr_ptr),
        .rd_eq_wr  (rd_eq_wr)
    );

    rrm_fetch_ctrl #(.AW(AW), .FW(FW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wide_mode     (wide_mode),
        .cmd_fetch     (cmd_fetch),
        .buf_full      (buf_full),
        .exh_ack       (exh_ack),
        .rd_ptr        (rd_ptr),
        .rd_eq_wr      (rd_eq_wr),
        .mem_ack       (mem_ack),
        .mem_rdata     (mem_rdata),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .adv           (adv),
        .buf_base      (buf_base),
        .buf_wcnt      (buf_wcnt),
        .cmd_pending   (cmd_pending),
        .busy          (busy),
        .rx_stop       (rx_stop),
        .irq_exhausted (irq_exhausted)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !rx_stop && !irq_exhausted && !cmd_pending));

endmodule

// File: tb/test_rx_ring_mgr.sv
module test_rx_ring_mgr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cmd_fetch = 1'b0;
    logic        cmd_pending;
    logic        buf_full = 1'b0;
    logic        exh_ack = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ack;
    logic [15:0] mem_rdata;
    logic [31:0] buf_base, buf_wcnt;
    logic        busy, rx_stop, irq_exhausted;

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] exp_q[$];

    always #5 clk = ~clk;

    rx_ring_mgr i_rx_ring_mgr (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_fetch(cmd_fetch), .cmd_pending(cmd_pending), .buf_full(buf_full),
        .exh_ack(exh_ack), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .buf_base(buf_base),
        .buf_wcnt(buf_wcnt), .busy(busy), .rx_stop(rx_stop), .irq_exhausted(irq_exhausted)
    );

    function automatic logic [15:0] mem_fn(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C3C;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // driver side: expected reads of one entry
    task automatic expect_entry(input logic [15:0] rd, input logic wide);
        for (int k = 0; k < 4; k++)
            exp_q.push_back(rd + (wide ? 16'(4 * k) : 16'(2 * k)));
    endtask

    // memory model and monitor
    initial begin
        int hold = 1;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (hold > 0) begin
                    hold--;
                end else begin
                    if (exp_q.size() == 0) begin
                        check("R11 unexpected read", {16'h0, mem_addr}, 32'hFFFF_FFFF);
                    end else begin
                        logic [15:0] a;
                        a = exp_q.pop_front();
                        check("R3 read address", {16'h0, mem_addr}, {16'h0, a});
                    end
                    mem_rdata = mem_fn(mem_addr);
                    mem_ack = 1'b1;
                    hold = 1;
                end
            end
        end
    end

    task automatic write_ptr(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic read_ptr(input logic [1:0] sel, output logic [15:0] val);
        @(negedge clk);
        reg_sel = sel;
        #1 val = reg_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!busy && !cmd_pending) break;
        end
    endtask

    task automatic pulse_cmd();
        @(negedge clk); cmd_fetch = 1'b1;
        @(negedge clk); cmd_fetch = 1'b0;
        wait_idle();
    endtask

    task automatic pulse_full();
        @(negedge clk); buf_full = 1'b1;
        @(negedge clk); buf_full = 1'b0;
        wait_idle();
    endtask

    task automatic check_entry(input string req, input logic [15:0] rd, input logic wide);
        logic [15:0] s;
        s = wide ? 16'd4 : 16'd2;
        check(req, buf_base, {mem_fn(rd + s), mem_fn(rd)});
        check(req, buf_wcnt, {mem_fn(rd + 3 * s), mem_fn(rd + 2 * s)});
    endtask

    initial begin
        #2_000_000;
        check("watchdog", 32'd0, 32'd1);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            read_ptr(2'(s), v);
            check("R1 pointer", {16'h0, v}, 32'h0);
        end
        check("R1 flags", {28'h0, busy, rx_stop, irq_exhausted, cmd_pending}, 32'h0);

        // R2 narrow masking
        wide_mode = 1'b0;
        write_ptr(2'd0, 16'h1001);
        write_ptr(2'd1, 16'h1021);
        write_ptr(2'd2, 16'h1000);
        write_ptr(2'd3, 16'h1019);
        read_ptr(2'd0, v); check("R2 narrow start", {16'h0, v}, 32'h1000);
        read_ptr(2'd3, v); check("R2 narrow write", {16'h0, v}, 32'h1018);

        // R3 R4 R7 command fetch
        expect_entry(16'h1000, 1'b0);
        @(negedge clk); cmd_fetch = 1'b1;
        @(negedge clk); cmd_fetch = 1'b0;
        check("R7 bit set", {31'h0, cmd_pending}, 32'h1);
        wait_idle();
        check("R7 self clear", {31'h0, cmd_pending}, 32'h0);
        check_entry("R3 entry", 16'h1000, 1'b0);
        read_ptr(2'd2, v); check("R4 narrow step", {16'h0, v}, 32'h1008);
        check("R6 no flag", {31'h0, irq_exhausted}, 32'h0);

        // R9 automatic fetches
        expect_entry(16'h1008, 1'b0);
        pulse_full();
        check_entry("R9 auto entry", 16'h1008, 1'b0);
        read_ptr(2'd2, v); check("R9 pointer", {16'h0, v}, 32'h1010);
        expect_entry(16'h1010, 1'b0);
        pulse_full();
        read_ptr(2'd2, v); check("R6 pointer", {16'h0, v}, 32'h1018);
        check("R6 flag set", {31'h0, irq_exhausted}, 32'h1);
        @(negedge clk); exh_ack = 1'b1;
        @(negedge clk); exh_ack = 1'b0;
        check("R6 ack", {31'h0, irq_exhausted}, 32'h0);

        // R8 stop latch, no fetch
        pulse_full();
        repeat (4) @(negedge clk);
        check("R8 latch", {31'h0, rx_stop}, 32'h1);
        check("R8 no busy", {31'h0, busy}, 32'h0);
        read_ptr(2'd2, v); check("R8 pointer held", {16'h0, v}, 32'h1018);
        pulse_full();
        repeat (4) @(negedge clk);
        check("R8 still stopped", {31'h0, rx_stop}, 32'h1);

        // R5 R10 wrap and release
        write_ptr(2'd3, 16'h1000);
        expect_entry(16'h1018, 1'b0);
        pulse_cmd();
        read_ptr(2'd2, v); check("R5 wrap narrow", {16'h0, v}, 32'h1000);
        check("R10 release", {31'h0, rx_stop}, 32'h0);
        check("R6 flag after wrap", {31'h0, irq_exhausted}, 32'h1);
        @(negedge clk); exh_ack = 1'b1;
        @(negedge clk); exh_ack = 1'b0;

        // wide mode
        wide_mode = 1'b1;
        write_ptr(2'd0, 16'h2003);
        write_ptr(2'd1, 16'h2043);
        write_ptr(2'd2, 16'h2031);
        write_ptr(2'd3, 16'h2002);
        read_ptr(2'd0, v); check("R2 wide start", {16'h0, v}, 32'h2000);
        read_ptr(2'd2, v); check("R2 wide read", {16'h0, v}, 32'h2030);
        expect_entry(16'h2030, 1'b1);
        pulse_cmd();
        check_entry("R3 wide entry", 16'h2030, 1'b1);
        read_ptr(2'd2, v); check("R5 wrap wide", {16'h0, v}, 32'h2000);
        check("R6 wide flag", {31'h0, irq_exhausted}, 32'h1);

        // R11 buffer close during a busy fetch
        write_ptr(2'd3, 16'h2020);
        expect_entry(16'h2000, 1'b1);
        @(negedge clk); cmd_fetch = 1'b1;
        @(negedge clk); cmd_fetch = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 busy", {31'h0, busy}, 32'h1);
        buf_full = 1'b1;
        @(negedge clk); buf_full = 1'b0;
        wait_idle();
        repeat (12) @(negedge clk);
        read_ptr(2'd2, v); check("R11 single step", {16'h0, v}, 32'h2010);
        check("R4 wide step", {16'h0, v}, 32'h2010);
        check("R11 queue drained", exp_q.size(), 32'd0);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule